// File: doc/BRIEF.md
# Bus-to-register bridge across two clock domains

This block connects a 32-bit memory-mapped slave port running on a CPU clock to a plain register interface running on an independent user clock. The CPU side follows the usual wait-request convention: a command is taken when wait-request is low. Reads return their data later with a read-data-valid pulse. The user side sees single-cycle write strobes and read requests. It answers a read with a valid pulse after whatever latency its register file needs.

Only one access is handled at a time. When a command is captured, its address, data, byte enables and direction are frozen in CPU-domain flops. A toggle carries the request into the user domain, and a second toggle carries the completion back. Wait-request stays high until that completion arrives, so the frozen fields are stable whenever the other domain samples them. A reset in either domain is carried across to the other domain, and both sides then return to idle.

Top module: `avmm_reg_bridge`

## Requirements
- R1: At most one command is in progress. Wait-request is high from capture until completion. It is low for exactly one CPU cycle per command, and that is the cycle in which the command is accepted.
- R2: Each write command produces exactly one single-cycle `reg_wr_en` pulse. The pulse carries the written data unchanged on `reg_wr_data`.
- R3: Byte enables pass through unchanged: `reg_wr_be[i]` qualifies `reg_wr_data[8*i+7:8*i]` for i = 0..3. A slave that merges only the enabled bytes therefore keeps its old value in every byte whose enable bit was 0.
- R4: Each read command produces exactly one single-cycle `reg_rd_req` pulse.
- R5: From a `reg_rd_req` pulse until the matching `reg_rd_valid`, `reg_addr` does not change and no other strobe is issued.
- R6: Read data captured at `reg_rd_valid` appears on `av_readdata`, with `av_readdatavalid` high for one CPU cycle. This is the cycle after the read's accepting cycle.
- R7: `reg_addr` is the byte address with its two low bits dropped (address / 4). The low two address bits have no effect.
- R8: While either reset is high, wait-request is high, read-data-valid is low and no user-side strobe is issued. After both resets are released, the bridge accepts commands normally, including a command that was held on the bus during the reset.
- R9: Wait-request remains high for as long as the user-side read has not been answered, whatever the read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-domain clock |
| cpu_rst | input | 1 | CPU-domain synchronous reset, active high |
| av_address | input | AW | Byte address |
| av_write | input | 1 | Write command |
| av_read | input | 1 | Read command |
| av_writedata | input | DW | Write data |
| av_byteenable | input | DW/8 | Byte enables of the write |
| av_waitrequest | output | 1 | Holds the command until it is accepted |
| av_readdata | output | DW | Returned read data |
| av_readdatavalid | output | 1 | Read data valid pulse |
| usr_clk | input | 1 | User-domain clock |
| usr_rst | input | 1 | User-domain synchronous reset, active high |
| reg_addr | output | AW-2 | Word address, shared by reads and writes |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wr_data | output | DW | Write data |
| reg_wr_be | output | DW/8 | Write byte enables |
| reg_rd_req | output | 1 | Single-cycle read request |
| reg_rd_data | input | DW | Data answered by the register slave |
| reg_rd_valid | input | 1 | Slave's read answer pulse |

## Verification
The bound checker watches, on every cycle, the properties that each edge of the bridge keeps locally. These are the one-cycle acceptance window, the single-cycle shape of both user strobes, and the stable address with no stray strobes while a read is outstanding. They also include the timing of read-data-valid relative to acceptance. Properties that span both domains can only be shown by the bench's scenarios. These are the data and byte-enable integrity of a sweep over all sixteen enable patterns, and the address truncation with nonzero low bits. They also include wait-request held across long read latencies and a command that is held through a user-domain reset and completes afterwards.

// File: rtl/avmm_reg_bridge.sv
module avmm_reg_bridge #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                    cpu_clk,
  input  logic                    cpu_rst,
  input  logic [AW-1:0]           av_address,
  input  logic                    av_write,
  input  logic                    av_read,
  input  logic [DW-1:0]           av_writedata,
  input  logic [DW/8-1:0]         av_byteenable,
  output logic                    av_waitrequest,
  output logic [DW-1:0]           av_readdata,
  output logic                    av_readdatavalid,
  input  logic                    usr_clk,
  input  logic                    usr_rst,
  output logic [AW-$clog2(DW/8)-1:0] reg_addr,
  output logic                    reg_wr_en,
  output logic [DW-1:0]           reg_wr_data,
  output logic [DW/8-1:0]         reg_wr_be,
  output logic                    reg_rd_req,
  input  logic [DW-1:0]           reg_rd_data,
  input  logic                    reg_rd_valid
);
  localparam int BW  = DW / 8;
  localparam int LSB = $clog2(BW);
  localparam int RAW = AW - LSB;

  typedef enum logic [1:0] {C_IDLE, C_WAIT, C_DONE} cstate_t;

  // reset crossing, each reset reaches the other domain
  logic [1:0] c_rsy, u_rsy;
  logic       c_rst, u_rst;
  always_ff @(posedge cpu_clk) c_rsy <= {c_rsy[0], usr_rst};
  always_ff @(posedge usr_clk) u_rsy <= {u_rsy[0], cpu_rst};
  assign c_rst = cpu_rst | c_rsy[1];
  assign u_rst = usr_rst | u_rsy[1];

  // CPU domain
  cstate_t        c_st;
  logic           c_req, c_rd;
  logic [1:0]     c_ack_s;
  logic [RAW-1:0] c_addr;
  logic [DW-1:0]  c_wdata;
  logic [BW-1:0]  c_be;
  logic           u_ack;
  logic [DW-1:0]  u_rdata;
  logic [LSB-1:0] unused_lsb;

  assign unused_lsb = av_address[LSB-1:0];

  always_ff @(posedge cpu_clk) begin
    if (c_rst) begin
      c_st             <= C_IDLE;
      c_req            <= 1'b0;
      c_rd             <= 1'b0;
      c_ack_s          <= '0;
      c_addr           <= '0;
      c_wdata          <= '0;
      c_be             <= '0;
      av_readdata      <= '0;
      av_readdatavalid <= 1'b0;
    end else begin
      c_ack_s          <= {c_ack_s[0], u_ack};
      av_readdatavalid <= 1'b0;
      case (c_st)
        C_IDLE: if (av_write || av_read) begin
          c_addr  <= av_address[AW-1:LSB];
          c_wdata <= av_writedata;
          c_be    <= av_byteenable;
          c_rd    <= av_read;
          c_req   <= ~c_req;
          c_st    <= C_WAIT;
        end
        C_WAIT: if (c_ack_s[1] == c_req) begin
          if (c_rd) av_readdata <= u_rdata;
          c_st <= C_DONE;
        end
        default: begin
          av_readdatavalid <= c_rd;
          c_st             <= C_IDLE;
        end
      endcase
    end
  end

  assign av_waitrequest = c_rst | (c_st != C_DONE);

  // user domain
  logic [1:0] u_sy;
  logic       u_seen, u_rdwait, u_new;

  assign u_new = (u_sy[1] != u_seen) & ~u_rst;

  always_ff @(posedge usr_clk) begin
    if (u_rst) begin
      u_sy     <= '0;
      u_seen   <= 1'b0;
      u_ack    <= 1'b0;
      u_rdwait <= 1'b0;
      u_rdata  <= '0;
    end else begin
      u_sy   <= {u_sy[0], c_req};
      u_seen <= u_sy[1];
      if (u_new && !c_rd) u_ack <= u_sy[1];
      if (u_new && c_rd) begin
        u_rdwait <= 1'b1;
      end else if (u_rdwait && reg_rd_valid) begin
        u_rdwait <= 1'b0;
        u_rdata  <= reg_rd_data;
        u_ack    <= u_seen;
      end
    end
  end

  assign reg_addr    = c_addr;
  assign reg_wr_data = c_wdata;
  assign reg_wr_be   = c_be;
  assign reg_wr_en   = u_new & ~c_rd;
  assign reg_rd_req  = u_new & c_rd;
endmodule

// File: rtl/avmm_reg_bridge_chk.sv
module avmm_reg_bridge_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic                    cpu_clk,
  input logic                    cpu_rst,
  input logic                    av_waitrequest,
  input logic                    av_readdatavalid,
  input logic                    usr_clk,
  input logic                    usr_rst,
  input logic [AW-$clog2(DW/8)-1:0] reg_addr,
  input logic                    reg_wr_en,
  input logic                    reg_rd_req,
  input logic                    reg_rd_valid
);
  logic pend;
  always_ff @(posedge usr_clk) begin
    if (usr_rst || cpu_rst) pend <= 1'b0;
    else if (reg_rd_req)    pend <= 1'b1;
    else if (reg_rd_valid)  pend <= 1'b0;
  end

  p_single_accept_r1: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    !av_waitrequest |=> av_waitrequest);

  p_rdvalid_after_accept_r6: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    av_readdatavalid |-> $past(!av_waitrequest));

  p_wr_pulse_r2: assert property (@(posedge usr_clk) disable iff (usr_rst)
    reg_wr_en |=> !reg_wr_en);

  p_rd_pulse_r4: assert property (@(posedge usr_clk) disable iff (usr_rst)
    reg_rd_req |=> !reg_rd_req);

  p_addr_hold_r5: assert property (@(posedge usr_clk) disable iff (usr_rst || cpu_rst)
    pend |-> $stable(reg_addr));

  p_no_strobe_pend_r5: assert property (@(posedge usr_clk) disable iff (usr_rst || cpu_rst)
    pend |-> !(reg_wr_en || reg_rd_req));
endmodule

bind avmm_reg_bridge avmm_reg_bridge_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_avmm_reg_bridge.sv
module test_avmm_reg_bridge;
  logic        cpu_clk = 0, usr_clk = 0;
  logic        cpu_rst = 1, usr_rst = 1;
  logic [15:0] av_address = 0;
  logic        av_write = 0, av_read = 0;
  logic [31:0] av_writedata = 0;
  logic [3:0]  av_byteenable = 0;
  logic        av_waitrequest;
  logic [31:0] av_readdata;
  logic        av_readdatavalid;
  logic [13:0] reg_addr;
  logic        reg_wr_en, reg_rd_req;
  logic [31:0] reg_wr_data;
  logic [3:0]  reg_wr_be;
  logic [31:0] reg_rd_data = 0;
  logic        reg_rd_valid = 0;

  always #4 cpu_clk = ~cpu_clk;
  always #3 usr_clk = ~usr_clk;

  avmm_reg_bridge i_avmm_reg_bridge (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  // register slave model
  logic [31:0] mem [16];
  int          lat = 0, cnt = 0;
  logic        pend = 0;
  logic [13:0] paddr = 0, last_waddr = 0;
  logic [31:0] last_wdata = 0;
  logic [3:0]  last_be = 0;
  int          wr_cnt = 0, rd_cnt = 0, strobe_in_rst = 0, addr_moved = 0;

  always @(posedge usr_clk) begin
    reg_rd_valid <= 1'b0;
    if (usr_rst) begin
      pend <= 1'b0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
      if (reg_wr_en || reg_rd_req) strobe_in_rst++;
    end else begin
      if (reg_wr_en) begin
        wr_cnt++;
        last_waddr <= reg_addr;
        last_wdata <= reg_wr_data;
        last_be    <= reg_wr_be;
        for (int b = 0; b < 4; b++)
          if (reg_wr_be[b]) mem[reg_addr[3:0]][b*8 +: 8] <= reg_wr_data[b*8 +: 8];
      end
      if (reg_rd_req) begin
        rd_cnt++;
        pend  <= 1'b1;
        paddr <= reg_addr;
        cnt   <= lat;
      end else if (pend) begin
        if (reg_addr != paddr) addr_moved++;
        if (cnt == 0) begin
          reg_rd_valid <= 1'b1;
          reg_rd_data  <= mem[paddr[3:0]];
          pend         <= 1'b0;
        end else cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dpat(input int a);
    return (32'h01020304 * (a + 1)) ^ 32'h5A5A5A5A;
  endfunction

  function automatic logic [31:0] bmask(input logic [3:0] be);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic av_wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge cpu_clk);
    av_address = a; av_writedata = d; av_byteenable = be; av_write = 1;
    do @(negedge cpu_clk); while (av_waitrequest);
    @(negedge cpu_clk);
    av_write = 0;
  endtask

  task automatic av_rd(input logic [15:0] a, output logic [31:0] d, output logic v);
    @(negedge cpu_clk);
    av_address = a; av_read = 1;
    do @(negedge cpu_clk); while (av_waitrequest);
    @(negedge cpu_clk);
    av_read = 0;
    v = av_readdatavalid;
    d = av_readdata;
  endtask

  initial begin
    repeat (100000) @(posedge cpu_clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    int n;
    repeat (10) @(negedge cpu_clk);
    chk(av_waitrequest == 1, "R8 waitreq in reset", {31'b0, av_waitrequest}, 1);
    chk(av_readdatavalid == 0, "R8 rdvalid in reset", {31'b0, av_readdatavalid}, 0);
    cpu_rst = 0; usr_rst = 0;
    repeat (8) @(negedge cpu_clk);

    // write sweep: every byte-enable pattern, nonzero low address bits
    for (int a = 0; a < 16; a++) begin
      n = wr_cnt;
      av_wr(16'(a * 4 + (a % 4)), dpat(a), 4'(a));
      chk(wr_cnt == n + 1, "R2 one write strobe", wr_cnt, n + 1);
      chk(last_wdata == dpat(a), "R2 write data", last_wdata, dpat(a));
      chk(last_be == 4'(a), "R3 byte enables", {28'b0, last_be}, a);
      chk(last_waddr == 14'(a), "R7 word address", {18'b0, last_waddr}, a);
    end

    // read sweep with varied latency
    for (int a = 0; a < 16; a++) begin
      lat = (a * 7) % 11;
      n = rd_cnt;
      av_rd(16'(a * 4 + 3 - (a % 4)), d, v);
      chk(rd_cnt == n + 1, "R4 one read request", rd_cnt, n + 1);
      chk(v == 1, "R6 read data valid", {31'b0, v}, 1);
      chk(d == (dpat(a) & bmask(4'(a))), "R3 merged read data", d, dpat(a) & bmask(4'(a)));
    end
    chk(addr_moved == 0, "R5 address held during read", addr_moved, 0);

    // overwrite with full enables, then partial
    av_wr(16'h0014, 32'hDEADBEEF, 4'hF);
    av_wr(16'h0014, 32'h00C0FFEE, 4'h2);
    lat = 2;
    av_rd(16'h0014, d, v);
    chk(d == 32'hDEADFFEF, "R3 partial overwrite", d, 32'hDEADFFEF);

    // long latency keeps wait-request high
    lat = 40;
    fork
      av_rd(16'h0020, d, v);
      begin
        repeat (14) @(negedge cpu_clk);
        chk(av_waitrequest == 1, "R9 waitreq held", {31'b0, av_waitrequest}, 1);
      end
    join
    chk(v == 1 && d == (dpat(8) & bmask(4'h8)), "R9 long read data", d, dpat(8) & bmask(4'h8));
    chk(addr_moved == 0, "R5 address held during long read", addr_moved, 0);

    // user reset while a write is held on the bus
    lat = 1;
    n = wr_cnt;
    @(negedge cpu_clk); usr_rst = 1;
    repeat (6) @(negedge cpu_clk);
    fork
      av_wr(16'h000C, 32'h12345678, 4'hF);
      begin
        repeat (8) @(negedge cpu_clk);
        chk(av_waitrequest == 1, "R8 waitreq during user reset", {31'b0, av_waitrequest}, 1);
        usr_rst = 0;
      end
    join
    chk(strobe_in_rst == 0, "R8 no strobe in reset", strobe_in_rst, 0);
    chk(wr_cnt == n + 1, "R8 held write completes once", wr_cnt, n + 1);
    av_rd(16'h000C, d, v);
    chk(v == 1 && d == 32'h12345678, "R8 read after user reset", d, 32'h12345678);

    // CPU reset pulse
    @(negedge cpu_clk); cpu_rst = 1;
    repeat (3) @(negedge cpu_clk);
    chk(av_waitrequest == 1, "R8 waitreq during cpu reset", {31'b0, av_waitrequest}, 1);
    chk(av_readdatavalid == 0, "R8 rdvalid during cpu reset", {31'b0, av_readdatavalid}, 0);
    cpu_rst = 0;
    repeat (8) @(negedge cpu_clk);
    av_rd(16'h000C, d, v);
    chk(v == 1 && d == 32'h12345678, "R1 access after cpu reset", d, 32'h12345678);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule